// File: doc/BRIEF.md
# Load-Store Memory Access Unit

This unit performs the data-memory operations of a 32-bit load-store processor. Each request carries a decoded I-format instruction word, the value of the base register and the value of the store-data register. The unit decodes the memory opcode, adds the sign-extended 16-bit displacement to the base, and checks the alignment of the resulting byte address. It then drives a word-wide synchronous memory port with per-byte write strobes. For loads it returns a sign-extended or full 32-bit result one cycle after the request.

A static input selects the byte order. With big-endian order the lowest byte address holds the most significant byte; with little-endian order it holds the least significant byte. The bits inside a byte are never reordered. Requests arrive on a valid-only stream: the unit takes one request in every cycle that `req_valid` is high and never applies back-pressure. The load-result stream has no ready input either, so the consumer must take `ld_data` in the cycle that `ld_valid` is high. The memory port is assumed to accept every access and to return read data one cycle after a read.

Top module: `ldst_unit`

## Requirements
- R1: For a supported, aligned request, `mem_req` is high in the request cycle and `mem_addr` equals bits 31:2 of base plus the 16-bit displacement (instr[15:0]) taken as signed, wrapping modulo 2^32. The opcode sits in instr[31:26].
- R2: Opcode 0x20 (byte load) returns the addressed byte in bits 7:0 of `ld_data` and copies its bit 7 into bits 31:8.
- R3: Opcode 0x21 (halfword load) returns the two bytes at the address, sign-extended from bit 15. In big-endian order the lower address is the upper byte; in little-endian order it is the lower byte.
- R4: Opcode 0x23 (word load) returns the four bytes at the address. In big-endian order the byte at the word address is bits 31:24; in little-endian order it is bits 7:0.
- R5: Opcode 0x28 (byte store) raises exactly one strobe bit and puts store_val[7:0] on that lane. Lane k is mem_wdata bits 8k+7:8k. With byte offset a = address bits 1:0, little-endian order uses lane a and big-endian order uses lane 3-a.
- R6: Opcode 0x2B (word store) raises all four strobe bits and drives `store_val` unchanged on `mem_wdata`. A later word load of the same address returns that value in either byte order.
- R7: A halfword access with address bit 0 set, or a word access with address bits 1:0 not 00, starts no memory access and raises `misalign` for exactly the next cycle. `ld_valid` stays low, `ld_data` keeps its previous value, and the addressed word is not modified. Byte accesses are never misaligned.
- R8: Any other opcode produces no memory access, no `misalign` and no `ld_valid`.
- R9: `ld_valid` is high exactly in the cycle after an accepted load request, and it is never high after a store.
- R10: During and right after reset, `ld_valid` and `misalign` are low and `ld_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Static byte order: 1 big-endian, 0 little-endian |
| req_valid | input | 1 | Request present this cycle |
| instr | input | 32 | I-format instruction word |
| base_val | input | 32 | Base register contents |
| store_val | input | 32 | Store data register contents |
| mem_req | output | 1 | Memory access this cycle |
| mem_addr | output | 30 | Word address (byte address bits 31:2) |
| mem_wstrb | output | 4 | Per-lane write strobes; zero means read |
| mem_wdata | output | 32 | Write data, lane k in bits 8k+7:8k |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Load result for the destination register |
| misalign | output | 1 | One-cycle misaligned-access flag |

## Verification
Two things can happen in the same cycle: the result of a load coming back, and the next request driving the memory port. That next request may be a store to the very word being returned, or a misaligned access that must leave the returned value in place. The bench issues requests back to back with random idle gaps. It forces these pairings with directed load, store, load and load, misaligned sequences. At each cycle it judges the previous request's result and the current request's port outputs together, against a byte-array shadow model run separately in each byte order.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int DATA_W  = 32;
  localparam int BYTES   = DATA_W / 8;
  localparam int LANE_W  = $clog2(BYTES);
  localparam int ADDR_W  = 32;
  localparam int WADDR_W = ADDR_W - LANE_W;
  localparam int OPC_W   = 6;
  localparam int DISP_W  = 16;

  localparam logic [OPC_W-1:0] OPC_LB = 6'h20;
  localparam logic [OPC_W-1:0] OPC_LH = 6'h21;
  localparam logic [OPC_W-1:0] OPC_LW = 6'h23;
  localparam logic [OPC_W-1:0] OPC_SB = 6'h28;
  localparam logic [OPC_W-1:0] OPC_SW = 6'h2B;

  typedef enum logic [2:0] {
    K_NONE, K_LB, K_LH, K_LW, K_SB, K_SW
  } acc_kind_e;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
(
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] base,
  output acc_kind_e         kind,
  output logic [ADDR_W-1:0] ea,
  output logic              misal
);
  always_comb begin
    unique case (opcode)
      OPC_LB:  kind = K_LB;
      OPC_LH:  kind = K_LH;
      OPC_LW:  kind = K_LW;
      OPC_SB:  kind = K_SB;
      OPC_SW:  kind = K_SW;
      default: kind = K_NONE;
    endcase
  end

  assign ea = base + {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};

  always_comb begin
    unique case (kind)
      K_LH:       misal = ea[0];
      K_LW, K_SW: misal = |ea[LANE_W-1:0];
      default:    misal = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  acc_kind_e         kind,
  input  logic [LANE_W-1:0] offs,
  input  logic              be,
  input  logic [DATA_W-1:0] store_val,
  output logic [BYTES-1:0]  wstrb,
  output logic [DATA_W-1:0] wdata
);
  logic [LANE_W-1:0] lane;
  assign lane = offs ^ {LANE_W{be}};

  always_comb begin
    wstrb = '0;
    wdata = '0;
    if (active) begin
      if (kind == K_SB) begin
        wdata = {BYTES{store_val[7:0]}};
        for (int k = 0; k < BYTES; k++)
          wstrb[k] = (lane == LANE_W'(k));
      end else if (kind == K_SW) begin
        wdata = store_val;
        wstrb = '1;
      end
    end
  end

  // R5: a byte store touches one lane only
  a_r5_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (active && kind == K_SB) |-> ($countones(wstrb) == 1));
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
(
  input  acc_kind_e         kind,
  input  logic [LANE_W-1:0] offs,
  input  logic              be,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] value
);
  logic [LANE_W-1:0] lane;
  logic              slot;
  logic [7:0]        byte_sel;
  logic [15:0]       half_sel;

  assign lane = offs ^ {LANE_W{be}};
  assign slot = offs[LANE_W-1] ^ be;

  always_comb begin
    byte_sel = '0;
    for (int k = 0; k < BYTES; k++)
      if (lane == LANE_W'(k)) byte_sel = rdata[8*k +: 8];
  end

  assign half_sel = slot ? rdata[DATA_W-1 -: 16] : rdata[15:0];

  always_comb begin
    unique case (kind)
      K_LB:    value = {{(DATA_W-8){byte_sel[7]}}, byte_sel};
      K_LH:    value = {{(DATA_W-16){half_sel[15]}}, half_sel};
      K_LW:    value = rdata;
      default: value = '0;
    endcase
  end
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import lsu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               big_endian,
  input  logic               req_valid,
  input  logic [31:0]        instr,
  input  logic [31:0]        base_val,
  input  logic [31:0]        store_val,
  output logic               mem_req,
  output logic [29:0]        mem_addr,
  output logic [3:0]         mem_wstrb,
  output logic [31:0]        mem_wdata,
  input  logic [31:0]        mem_rdata,
  output logic               ld_valid,
  output logic [31:0]        ld_data,
  output logic               misalign
);
  acc_kind_e         kind;
  logic [ADDR_W-1:0] ea;
  logic              misal_d;
  logic              supported, access, is_load, is_store;
  logic              unused_fields;

  assign unused_fields = ^instr[25:16];

  lsu_decode u_decode (
    .opcode (instr[31:26]),
    .disp   (instr[15:0]),
    .base   (base_val),
    .kind   (kind),
    .ea     (ea),
    .misal  (misal_d)
  );

  assign supported = req_valid && (kind != K_NONE);
  assign access    = supported && !misal_d;
  assign is_load   = (kind == K_LB) || (kind == K_LH) || (kind == K_LW);
  assign is_store  = (kind == K_SB) || (kind == K_SW);

  assign mem_req  = access;
  assign mem_addr = ea[ADDR_W-1:LANE_W];

  lsu_store_steer u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (access && is_store),
    .kind      (kind),
    .offs      (ea[LANE_W-1:0]),
    .be        (big_endian),
    .store_val (store_val),
    .wstrb     (mem_wstrb),
    .wdata     (mem_wdata)
  );

  logic              pend_q, misal_q;
  acc_kind_e         kind_q;
  logic [LANE_W-1:0] offs_q;
  logic [DATA_W-1:0] hold_q, ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      misal_q <= 1'b0;
      kind_q  <= K_NONE;
      offs_q  <= '0;
      hold_q  <= '0;
    end else begin
      pend_q  <= access && is_load;
      misal_q <= supported && misal_d;
      kind_q  <= kind;
      offs_q  <= ea[LANE_W-1:0];
      if (pend_q) hold_q <= ext;
    end
  end

  lsu_load_extract u_extract (
    .kind  (kind_q),
    .offs  (offs_q),
    .be    (big_endian),
    .rdata (mem_rdata),
    .value (ext)
  );

  assign ld_valid = pend_q;
  assign ld_data  = pend_q ? ext : hold_q;
  assign misalign = misal_q;

  // R7: a trapped access yields no load result
  a_r7_flag_excludes_result: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> !ld_valid);
  // R7: without a new result the returned value does not move
  a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> $stable(ld_data));
  // R9: a read on the port is answered in the next cycle
  a_r9_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_wstrb == 4'b0000) |=> ld_valid);
  // R9: a result only follows a read access
  a_r9_result_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_req && mem_wstrb == 4'b0000));
  // R6: strobes never appear without an access
  a_r6_strobe_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_wstrb) |-> mem_req);
endmodule

// File: tb/test_ldst_unit.sv
module test_ldst_unit;
  localparam int CLK_P = 10;
  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0, rst_n = 1'b0, big_endian = 1'b0, req_valid = 1'b0;
  logic [31:0] instr = '0, base_val = '0, store_val = '0, mem_rdata = '0;
  logic        mem_req, ld_valid, misalign;
  logic [29:0] mem_addr;
  logic [3:0]  mem_wstrb;
  logic [31:0] mem_wdata, ld_data;

  ldst_unit i_ldst_unit (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .req_valid(req_valid),
    .instr(instr), .base_val(base_val), .store_val(store_val),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wstrb(mem_wstrb),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ld_valid(ld_valid),
    .ld_data(ld_data), .misalign(misalign)
  );

  always #(CLK_P/2) clk = ~clk;

  logic [31:0] tmem [16];
  logic [7:0]  shadow [64];

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_wstrb == 4'b0000) mem_rdata <= tmem[mem_addr[3:0]];
      else for (int k = 0; k < 4; k++)
        if (mem_wstrb[k]) tmem[mem_addr[3:0]][8*k +: 8] <= mem_wdata[8*k +: 8];
    end
  end

  int checks = 0, errors = 0, cycles = 0;
  logic        p_ld, p_mis;
  logic [31:0] p_val, last_ld;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [31:0] v, input int w);
    return (w == 8) ? {{24{v[7]}}, v[7:0]} : {{16{v[15]}}, v[15:0]};
  endfunction

  // byte offset a of a word sits in lane a (little) or lane 3-a (big)
  function automatic int lane_of(input int a);
    return big_endian ? 3 - a : a;
  endfunction

  function automatic logic [31:0] exp_load(input logic [5:0] opc, input logic [5:0] ea);
    logic [7:0] b0, b1, b2, b3;
    b0 = shadow[ea]; b1 = shadow[ea+6'd1]; b2 = shadow[ea+6'd2]; b3 = shadow[ea+6'd3];
    case (opc)
      6'h20:   return sx({24'h0, b0}, 8);
      6'h21:   return big_endian ? sx({16'h0, b0, b1}, 16) : sx({16'h0, b1, b0}, 16);
      default: return big_endian ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
    endcase
  endfunction

  task automatic init_mem();
    for (int w = 0; w < 16; w++) begin
      tmem[w] = $urandom;
      for (int k = 0; k < 4; k++) shadow[4*w + lane_of(k)] = tmem[w][8*k +: 8];
    end
  endtask

  // One cycle: judge previous result, present and judge this request.
  task automatic issue(input logic v, input logic [5:0] opc, input logic [31:0] ea,
                       input logic [15:0] off, input logic [31:0] sval);
    logic sup, ld, st, mis;
    logic [3:0] es;
    @(negedge clk);
    chk(ld_valid == p_ld, "R9 ld_valid", {31'b0, ld_valid}, {31'b0, p_ld});
    chk(misalign == p_mis, "R7 misalign", {31'b0, misalign}, {31'b0, p_mis});
    if (p_ld) begin
      chk(ld_data == p_val, "R2/R3/R4 load data", ld_data, p_val);
      last_ld = p_val;
    end else chk(ld_data == last_ld, "R7 ld_data held", ld_data, last_ld);
    sup = v && (opc == 6'h20 || opc == 6'h21 || opc == 6'h23 || opc == 6'h28 || opc == 6'h2B);
    ld  = (opc == 6'h20 || opc == 6'h21 || opc == 6'h23);
    st  = (opc == 6'h28 || opc == 6'h2B);
    mis = (opc == 6'h21 && ea[0]) || ((opc == 6'h23 || opc == 6'h2B) && ea[1:0] != 2'b00);
    req_valid = v;
    instr = {opc, 5'($urandom), 5'($urandom), off};
    base_val = ea - {{16{off[15]}}, off};
    store_val = sval;
    #1;
    if (sup && !mis) begin
      chk(mem_req, "R1 mem_req", {31'b0, mem_req}, 32'd1);
      chk(mem_addr == ea[31:2], "R1 mem_addr", {2'b0, mem_addr}, {2'b0, ea[31:2]});
      es = (opc == 6'h2B) ? 4'hF : (opc == 6'h28) ? 4'(1 << lane_of(int'(ea[1:0]))) : 4'h0;
      chk(mem_wstrb == es, st ? "R5/R6 strobe" : "R9 load strobe", {28'b0, mem_wstrb}, {28'b0, es});
      if (opc == 6'h2B) begin
        chk(mem_wdata == sval, "R6 wdata", mem_wdata, sval);
        for (int k = 0; k < 4; k++)
          shadow[ea[5:0] + 6'(k)] = big_endian ? sval[8*(3-k) +: 8] : sval[8*k +: 8];
      end
      if (opc == 6'h28) begin
        chk(mem_wdata[8*lane_of(int'(ea[1:0])) +: 8] == sval[7:0], "R5 lane data",
            {24'b0, mem_wdata[8*lane_of(int'(ea[1:0])) +: 8]}, {24'b0, sval[7:0]});
        shadow[ea[5:0]] = sval[7:0];
      end
    end else begin
      chk(!mem_req && mem_wstrb == 4'h0, mis ? "R7 no access" : "R8 no access",
          {27'b0, mem_req, mem_wstrb}, 32'd0);
    end
    p_ld  = sup && !mis && ld;
    p_mis = sup && mis;
    p_val = p_ld ? exp_load(opc, ea[5:0]) : 32'h0;
  endtask

  task automatic idle();
    issue(1'b0, 6'h00, 32'h0, 16'h0, 32'h0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int be = 0; be < 2; be++) begin
      rst_n = 1'b0; req_valid = 1'b0; big_endian = be[0];
      init_mem();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!ld_valid && !misalign && ld_data == 0, "R10 reset state",
          {ld_valid, misalign, ld_data[29:0]}, 32'd0);
      rst_n = 1'b1;
      p_ld = 1'b0; p_mis = 1'b0; p_val = '0; last_ld = '0;
      idle();
      // directed corner cases
      issue(1'b1, 6'h23, 32'd8, 16'h8000, 32'h0);          // R1 most negative displacement
      issue(1'b1, 6'h2B, 32'd8, 16'h7FFF, 32'h80FF_7F01);  // R6 store while load returns
      issue(1'b1, 6'h23, 32'd8, 16'h0004, 32'h0);          // R6 read-back
      issue(1'b1, 6'h28, 32'd9, 16'hFFF0, 32'hAAAA_AA85);  // R5 store byte
      issue(1'b1, 6'h20, 32'd9, 16'h0000, 32'h0);          // R2 negative byte
      issue(1'b1, 6'h21, 32'd10, 16'h0002, 32'h0);         // R3 upper halfword
      issue(1'b1, 6'h21, 32'd13, 16'h0000, 32'h0);         // R7 odd halfword after load
      issue(1'b1, 6'h23, 32'd18, 16'h0000, 32'h0);         // R7 word offset 2
      issue(1'b1, 6'h2B, 32'd19, 16'h0000, 32'hDEAD_BEEF);  // R7 misaligned store, no write
      issue(1'b1, 6'h23, 32'd16, 16'h0000, 32'h0);         // R7 word untouched
      issue(1'b1, 6'h29, 32'd20, 16'h0000, 32'h1234_5678); // R8 unsupported
      issue(1'b1, 6'h00, 32'd20, 16'h0000, 32'h0);         // R8 unsupported
      issue(1'b1, 6'h20, 32'd63, 16'h0001, 32'h0);         // R2 last byte
      // constrained random
      for (int i = 0; i < 400; i++) begin
        logic [5:0] opc;
        logic [31:0] ea;
        int r;
        r = int'($urandom % 100);
        if (r < 15) begin idle(); continue; end
        case ($urandom % 7)
          0: opc = 6'h20; 1: opc = 6'h21; 2: opc = 6'h23; 3: opc = 6'h28;
          4: opc = 6'h2B; 5: opc = 6'h23;
          default: opc = ($urandom % 2) ? 6'h22 : 6'h3F;
        endcase
        ea = 32'($urandom % 61);
        if ($urandom % 4 != 0) begin
          if (opc == 6'h21) ea[0] = 1'b0;
          if (opc == 6'h23 || opc == 6'h2B) ea[1:0] = 2'b00;
        end
        issue(1'b1, opc, ea, 16'($urandom), $urandom);
      end
      idle();
      idle();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule